// File: doc/BRIEF.md
# Laplacian Edge Filter with APB Register Interface

This block is a memory-mapped filter that runs a fixed 3x3 Laplacian kernel over a grayscale image. The image arrives one pixel at a time, in raster order. Software writes the image width and height, then starts a frame. It then pushes 8-bit pixels into an input register, and after each push it reads one filtered 8-bit pixel back from an output register. Every accepted input pixel yields exactly one output, so a frame of W×H inputs gives W×H outputs.

The block keeps the two previous image rows in two line buffers. It also holds a small window of the last two columns. When a pixel at row r, column c is accepted, the window is complete for the neighbourhood centred on (r−1, c−1). The output for that push is 4·centre − north − south − west − east, computed with shifts and adds and clamped to 0..255. A push whose centre lies on the image border (r < 2 or c < 2) gives 0. An output-valid flag gives back-pressure. A push made while the previous result is still unread is dropped.

Top module: `lap_edge_top`

## Requirements
- R1: After reset the status register (0x04) reads 0, the output register (0x10) reads 0, and pready is 1.
- R2: Width (0x08) and height (0x14) read back what was written while the block is idle. A write to either while busy leaves the value unchanged.
- R3: For the push of pixel x(r,c) with r ≥ 2 and c ≥ 2, the output register then holds 4·x(r−1,c−1) − x(r−2,c−1) − x(r,c−1) − x(r−1,c−2) − x(r−1,c), clamped to 0..255.
- R4: For the push of a pixel with row < 2 or column < 2, the output register then holds 0.
- R5: Every accepted push sets status bit 2 (output valid). A read of 0x10 clears it.
- R6: A write to 0x0C while status bit 2 is set is ignored. The output value does not change and the pixel is not counted in the frame.
- R7: A write to 0x0C while status bit 0 (busy) is clear is ignored. Output valid stays 0 and the output value does not change.
- R8: Writing 1 to control bit 0 (address 0x00) sets busy and clears done (status bit 1). After W×H accepted pushes, busy clears and done sets. Done stays set until the next start.
- R9: Writing 1 to control bit 1 (soft reset) clears busy, done and output valid, and restarts row and column tracking. The next frame is then filtered correctly from its first pixel.
- R10: A raw result below 0 is output as 0, and a raw result above 255 is output as 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1, so there are no wait states |

## Verification
The bench runs random frames of several widths. Pixels are mixed between random values and the extremes 0 and 255, so both clamps are exercised. If the line buffers or window were misaligned, interior outputs would take a wrong neighbour. If row and column tracking were off, outputs in the first two rows and columns would be nonzero.

Directed cases cover three dropped pushes:
- a second push before the read, which a faulty design would count, ending the frame early and shifting later outputs;
- a push while idle;
- width changes attempted mid-frame.

A soft reset in the middle of a frame is followed by a full frame. A design that kept stale column state would corrupt that frame's border pattern.

// File: rtl/lap_pkg.sv
package lap_pkg;
  typedef struct packed {
    logic start;
    logic clear;
    logic push;
  } lapStrobe_t;

  localparam logic [7:0] ADDR_CTRL   = 8'h00;
  localparam logic [7:0] ADDR_STAT   = 8'h04;
  localparam logic [7:0] ADDR_WIDTH  = 8'h08;
  localparam logic [7:0] ADDR_PIXIN  = 8'h0C;
  localparam logic [7:0] ADDR_PIXOUT = 8'h10;
  localparam logic [7:0] ADDR_HEIGHT = 8'h14;
endpackage

// File: rtl/lap_ctrl.sv
module lap_ctrl
  import lap_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 1024,
  parameter int MAX_H = 1024,
  localparam int WID_W = $clog2(MAX_W + 1),
  localparam int HGT_W = $clog2(MAX_H + 1),
  localparam int CNT_W = WID_W + HGT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [7:0]        paddr,
  input  logic [31:0]       pwdata,
  input  logic [PIX_W-1:0]  outPix,
  output logic [31:0]       prdata,
  output lapStrobe_t        strb,
  output logic [PIX_W-1:0]  pixIn,
  output logic [WID_W-1:0]  widthReg
);
  logic             access, wrEn, rdEn;
  logic             busy, done, outValid;
  logic [HGT_W-1:0] heightReg;
  logic [CNT_W-1:0] pixCnt, frameTotal;

  assign access = psel & penable;
  assign wrEn   = access & pwrite;
  assign rdEn   = access & ~pwrite;

  assign strb.clear = wrEn && (paddr == ADDR_CTRL) && pwdata[1];
  assign strb.start = wrEn && (paddr == ADDR_CTRL) && pwdata[0] && !pwdata[1];
  assign strb.push  = wrEn && (paddr == ADDR_PIXIN) && busy && !outValid;
  assign pixIn      = pwdata[PIX_W-1:0];
  assign frameTotal = CNT_W'(widthReg) * CNT_W'(heightReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      outValid  <= 1'b0;
      pixCnt    <= '0;
      widthReg  <= '0;
      heightReg <= '0;
    end else if (strb.clear) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      outValid <= 1'b0;
      pixCnt   <= '0;
    end else begin
      if (rdEn && paddr == ADDR_PIXOUT) outValid <= 1'b0;
      if (strb.start) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        outValid <= 1'b0;
        pixCnt   <= '0;
      end else if (strb.push) begin
        pixCnt   <= pixCnt + 1'b1;
        outValid <= 1'b1;
        if (pixCnt + 1'b1 == frameTotal) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (wrEn && !busy && paddr == ADDR_WIDTH)  widthReg  <= pwdata[WID_W-1:0];
      if (wrEn && !busy && paddr == ADDR_HEIGHT) heightReg <= pwdata[HGT_W-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      ADDR_STAT:   prdata = {29'd0, outValid, done, busy};
      ADDR_WIDTH:  prdata = 32'(widthReg);
      ADDR_HEIGHT: prdata = 32'(heightReg);
      ADDR_PIXOUT: prdata = 32'(outPix);
      default:     prdata = '0;
    endcase
  end

  a_r5_push_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> outValid);
  a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !strb.start && !strb.clear) |=> $stable(pixCnt));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !strb.start && !strb.clear) |=> done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/lap_datapath.sv
module lap_datapath
  import lap_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 1024,
  localparam int WID_W = $clog2(MAX_W + 1),
  localparam int COL_W = $clog2(MAX_W),
  localparam int ACC_W = PIX_W + 3,
  localparam int N_LB  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lapStrobe_t        strb,
  input  logic [PIX_W-1:0]  pixIn,
  input  logic [WID_W-1:0]  widthReg,
  output logic [PIX_W-1:0]  outPix
);
  logic [COL_W-1:0] colIdx;
  logic [1:0]       rowCnt;
  logic [PIX_W-1:0] lbIn  [N_LB];
  logic [PIX_W-1:0] lbOut [N_LB];
  logic [PIX_W-1:0] c1Top, c1Mid, c1Bot, c2Mid;
  logic signed [ACC_W-1:0] acc;
  logic [PIX_W-1:0] clamped;
  logic             interior, lastCol;

  assign lbIn[0] = pixIn;

  for (genvar g = 0; g < N_LB; g++) begin : g_line
    logic [PIX_W-1:0] mem [MAX_W];
    always_ff @(posedge clk) begin
      if (strb.push) mem[colIdx] <= lbIn[g];
    end
    assign lbOut[g] = mem[colIdx];
    if (g + 1 < N_LB) begin : g_chain
      assign lbIn[g+1] = lbOut[g];
    end
  end

  // centre (r-1,c-1): north from oldest row, south from current row
  assign acc = $signed({1'b0, c1Mid, 2'b00})
             - $signed(ACC_W'(c1Top)) - $signed(ACC_W'(c1Bot))
             - $signed(ACC_W'(c2Mid)) - $signed(ACC_W'(lbOut[0]));

  always_comb begin
    if (acc < 0)
      clamped = '0;
    else if (acc > $signed(ACC_W'({PIX_W{1'b1}})))
      clamped = '1;
    else
      clamped = acc[PIX_W-1:0];
  end

  assign interior = (rowCnt == 2'd2) && (colIdx >= COL_W'(2));
  assign lastCol  = (WID_W'(colIdx) == widthReg - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colIdx <= '0;
      rowCnt <= '0;
      outPix <= '0;
      c1Top  <= '0;
      c1Mid  <= '0;
      c1Bot  <= '0;
      c2Mid  <= '0;
    end else if (strb.clear || strb.start) begin
      colIdx <= '0;
      rowCnt <= '0;
      outPix <= '0;
    end else if (strb.push) begin
      outPix <= interior ? clamped : '0;
      c2Mid  <= c1Mid;
      c1Top  <= lbOut[1];
      c1Mid  <= lbOut[0];
      c1Bot  <= pixIn;
      if (lastCol) begin
        colIdx <= '0;
        if (rowCnt != 2'd2) rowCnt <= rowCnt + 1'b1;
      end else begin
        colIdx <= colIdx + 1'b1;
      end
    end
  end

  a_r4_border_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.start && !strb.clear && !interior) |=> (outPix == '0));
  a_r3_col_in_row: assert property (@(posedge clk) disable iff (!rstN)
    (widthReg != '0) |-> (WID_W'(colIdx) < widthReg));
endmodule

// File: rtl/lap_edge_top.sv
module lap_edge_top
  import lap_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 1024,
  parameter int MAX_H = 1024,
  localparam int WID_W = $clog2(MAX_W + 1)
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready
);
  lapStrobe_t       strb;
  logic [PIX_W-1:0] pixIn, outPix;
  logic [WID_W-1:0] widthReg;

  assign pready = 1'b1;

  lap_ctrl #(.PIX_W(PIX_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .outPix(outPix),
    .prdata(prdata), .strb(strb), .pixIn(pixIn), .widthReg(widthReg)
  );

  lap_datapath #(.PIX_W(PIX_W), .MAX_W(MAX_W)) u_dp (
    .clk(pclk), .rstN(presetn), .strb(strb), .pixIn(pixIn),
    .widthReg(widthReg), .outPix(outPix)
  );
endmodule

// File: tb/sim_lap_edge_top.sv
module sim_lap_edge_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;
  logic [7:0] frame [256];

  always #2 clk = ~clk;

  lap_edge_top u0 (
    .pclk(clk), .presetn(rstN), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready)
  );

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apbWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRd(logic [7:0] a, output int d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = int'(prdata);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic int rawAt(int k, int w);
    int r = k / w;
    int c = k % w;
    if (r < 2 || c < 2) return 0;
    return 4 * frame[(r-1)*w + c-1] - frame[(r-2)*w + c-1] - frame[r*w + c-1]
           - frame[(r-1)*w + c-2] - frame[(r-1)*w + c];
  endfunction

  function automatic int expAt(int k, int w);
    int v = rawAt(k, w);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic string tagAt(int k, int w);
    int v = rawAt(k, w);
    if ((k / w) < 2 || (k % w) < 2) return "R4";
    if (v < 0 || v > 255) return "R10";
    return "R3";
  endfunction

  task automatic runFrame(int w, int h, bit poke);
    int d;
    apbWr(8'h08, 32'(w));
    apbWr(8'h14, 32'(h));
    apbWr(8'h00, 32'h1);
    apbRd(8'h04, d);
    check("R8 start sets busy", d, 1);
    if (poke) begin
      apbWr(8'h08, 32'(w + 3));
      apbRd(8'h08, d);
      check("R2 width locked while busy", d, w);
    end
    for (int k = 0; k < w * h; k++) begin
      apbWr(8'h0C, 32'(frame[k]));
      apbRd(8'h04, d);
      check("R5 valid after push", (d >> 2) & 1, 1);
      if (poke && (k % 5 == 3)) begin
        apbWr(8'h0C, 32'(~frame[k] & 8'hFF));
        apbRd(8'h04, d);
        check("R6 valid kept", (d >> 2) & 1, 1);
      end
      apbRd(8'h10, d);
      check(tagAt(k, w), d, expAt(k, w));
      if (k % 4 == 0) begin
        apbRd(8'h04, d);
        check("R5 read clears valid", (d >> 2) & 1, 0);
      end
    end
    apbRd(8'h04, d);
    check("R8 done at frame end", d, 2);
  endtask

  task automatic fillRandom(int n);
    for (int k = 0; k < n; k++) begin
      case ($urandom % 4)
        0: frame[k] = 8'd0;
        1: frame[k] = 8'd255;
        default: frame[k] = 8'($urandom);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    apbRd(8'h04, d); check("R1 status", d, 0);
    apbRd(8'h10, d); check("R1 output", d, 0);
    check("R1 pready", int'(pready), 1);

    // R2 readback while idle
    apbWr(8'h08, 32'd9); apbRd(8'h08, d); check("R2 width", d, 9);
    apbWr(8'h14, 32'd6); apbRd(8'h14, d); check("R2 height", d, 6);

    // R7 push while idle
    apbWr(8'h0C, 32'd77);
    apbRd(8'h04, d); check("R7 idle push no valid", d, 0);
    apbRd(8'h10, d); check("R7 idle push no data", d, 0);

    // R10 directed: bright centre saturates high
    for (int k = 0; k < 9; k++) frame[k] = 8'd0;
    frame[4] = 8'd255;
    runFrame(3, 3, 1'b0);
    // R8 done clears on start
    apbWr(8'h00, 32'h1);
    apbRd(8'h04, d); check("R8 start clears done", d, 1);
    // R10 dark centre saturates low
    for (int k = 0; k < 9; k++) frame[k] = 8'd255;
    frame[4] = 8'd0;
    runFrame(3, 3, 1'b0);
    // R3 mid-range directed
    for (int k = 0; k < 9; k++) frame[k] = 8'd5;
    frame[4] = 8'd50; frame[1] = 8'd10; frame[7] = 8'd20;
    frame[3] = 8'd30; frame[5] = 8'd40;
    runFrame(3, 3, 1'b0);

    // R7 push after done does not change output
    apbRd(8'h10, d);
    apbWr(8'h0C, 32'd200);
    apbRd(8'h04, d); check("R7 push after done no valid", (d >> 2) & 1, 0);
    apbRd(8'h10, d); check("R7 push after done data", d, expAt(8, 3));

    // random frames, R6 pokes and R2 locking
    fillRandom(6 * 5);  runFrame(6, 5, 1'b1);
    fillRandom(11 * 7); runFrame(11, 7, 1'b0);
    fillRandom(4 * 9);  runFrame(4, 9, 1'b1);

    // R9 soft reset mid-frame
    apbWr(8'h08, 32'd7); apbWr(8'h14, 32'd4); apbWr(8'h00, 32'h1);
    for (int k = 0; k < 5; k++) begin
      apbWr(8'h0C, 32'($urandom % 256));
      apbRd(8'h10, d);
    end
    apbWr(8'h0C, 32'd9);
    apbWr(8'h00, 32'h2);
    apbRd(8'h04, d); check("R9 soft reset clears status", d, 0);
    fillRandom(7 * 4); runFrame(7, 4, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule